// File: doc/BRIEF.md
# Nested Software-Priority Interrupt Controller

This block decides which interrupt a small CPU takes next. Each maskable source has a 2-bit software level. The levels sit four to a byte in priority registers that software writes and reads back. The controller keeps the CPU's current level as a 2-bit code. Every cycle it looks at the sources that are requesting. A source is granted only if its level is strictly above the current level.

On a grant the controller does three things. It pushes the old level onto an internal nesting stack, raises the current level to the granted source's level, and presents the fixed vector address for that source. Two non-maskable requests do not use the software levels. A reset request restarts the controller, and a software trap nests like an interrupt. Both force the top level.

The CPU reports the events that change the current level on single-cycle strobes: return from interrupt, enable, disable, and load of a level popped from memory. The block arbitrates the pending requests again on the cycle after each such event.

Top module: `swpic_top`

## Requirements
- R1: After rst_n is released, cur_lvl is 2'b11, grant is 0, and every priority register reads 8'hFF (all fields 2'b11).
- R2: A write to priority register pr_addr updates each 2-bit field on its own. A field whose written code is 2'b10 keeps its old value. Field k of register r holds source 4r+k at bits [2k+1:2k]. Writing 8'h64 over a stored 8'hCF leaves 8'h44.
- R3: Level codes rank as follows: 2'b10 = 0, 2'b01 = 1, 2'b00 = 2, 2'b11 = 3. A requesting source is granted only when its rank is strictly greater than the rank of cur_lvl. At cur_lvl = 2'b11, no maskable source is granted.
- R4: When several eligible sources share the highest rank, the one with the lowest index is granted.
- R5: A maskable grant appears one clock after the deciding edge. At that point grant is 1, grant_src is the source index, cur_lvl is the source's level, and grant_vec is 16'hFFF8 - 2*i, floored at 16'hFFE0. Sources 12 and 13 therefore both use 16'hFFE0.
- R6: A trap_req pulse is held pending until it is taken, whatever the software levels are. It is taken even at level 2'b11. The grant gives grant_src 14, grant_vec 16'hFFFA and cur_lvl 2'b11, and it pushes the old level.
- R7: A rst_req grants at once with grant_src 15 and grant_vec 16'hFFFE. It sets cur_lvl to 2'b11, empties the nesting stack and drops a pending trap. It takes precedence over every other input.
- R8: iret pops the most recently saved level into cur_lvl. It is ignored when the stack is empty. No grant is made in the iret cycle, and pending requests are arbitrated again in the following cycle.
- R9: op_en loads 2'b10, op_dis loads 2'b11, and op_pop loads pop_lvl into cur_lvl. The order of precedence is rst_req, iret, op_en, op_dis, op_pop, trap, maskable. No grant is made in a cycle that carries an event.
- R10: If a source in service is still requesting and software raises its level above cur_lvl, the source is granted again. If the new level is not above cur_lvl, cur_lvl stays unchanged.
- R11: While the stack holds STK_DEPTH (4) saved levels, neither maskable nor trap grants are made. They resume after an iret frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Level-held maskable requests |
| trap_req | input | 1 | Software trap strobe |
| rst_req | input | 1 | Non-maskable restart request |
| iret | input | 1 | Return-from-interrupt strobe |
| op_en | input | 1 | Enable strobe (level 2'b10) |
| op_dis | input | 1 | Disable strobe (level 2'b11) |
| op_pop | input | 1 | Load pop_lvl into the current level |
| pop_lvl | input | 2 | Level code popped from memory |
| pr_we | input | 1 | Priority register write enable |
| pr_addr | input | AW | Priority register select |
| pr_wdata | input | 8 | Priority register write data |
| pr_rdata | output | 8 | Priority register read data (combinational) |
| cur_lvl | output | 2 | Current CPU level code |
| grant | output | 1 | One-cycle grant pulse |
| grant_src | output | IW | Granted id: source index, 14 trap, 15 restart |
| grant_vec | output | 16 | Vector address of the grant |

## Verification
A corrupted priority field is visible at once on pr_rdata. It also shows as a wrong grant_src one clock after a request. A wrong saved level in the nesting stack stays hidden until the matching iret, and then shows on cur_lvl in the cycle after that strobe. A stack count that drifts shows as either a grant that should have been blocked or a missing one at the fourth nesting level. Random priority contents and request patterns are checked against a bench model of ranking and tie order. Directed cases cover re-entry, trap pending and a full stack.

// File: rtl/swpic_pkg.sv
package swpic_pkg;
   typedef logic [1:0] lvl_t;

   localparam lvl_t LVL_R0 = 2'b10;
   localparam lvl_t LVL_R1 = 2'b01;
   localparam lvl_t LVL_R2 = 2'b00;
   localparam lvl_t LVL_R3 = 2'b11;

   // numeric rank of a level code; higher wins
   function automatic logic [1:0] lvl_rank(input lvl_t code);
      logic [1:0] r;
      case (code)
         LVL_R0:  r = 2'd0;
         LVL_R1:  r = 2'd1;
         LVL_R2:  r = 2'd2;
         default: r = 2'd3;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/swpic_prio_regs.sv
module swpic_prio_regs
   import swpic_pkg::*;
#(
   parameter int NUM_SRC = 14,
   localparam int NREG   = (NUM_SRC + 3) / 4,
   localparam int NFLD   = NREG * 4,
   localparam int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [AW-1:0]        addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata,
   output logic [2*NUM_SRC-1:0] prio_flat
);
   lvl_t fld [NFLD];

   for (genvar g = 0; g < NFLD; g++) begin : g_fld
      localparam int R = g / 4;
      localparam int F = g % 4;
      logic hit;
      assign hit = we && (addr == AW'(R));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld[g] <= LVL_R3;
         else if (hit && (wdata[2*F +: 2] != LVL_R0))
            fld[g] <= wdata[2*F +: 2];
      end

      p_keep_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wdata[2*F +: 2] == LVL_R0) |=> (fld[g] == $past(fld[g])));

      p_never_lvl0_r2: assert property (@(posedge clk) disable iff (!rst_n)
         fld[g] != LVL_R0);
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
      assign prio_flat[2*s +: 2] = fld[s];
   end

   always_comb begin
      rdata = '0;
      if (int'(addr) < NREG) begin
         for (int f = 0; f < 4; f++)
            rdata[2*f +: 2] = fld[int'(addr)*4 + f];
      end
   end
endmodule

// File: rtl/swpic_arbiter.sv
module swpic_arbiter
   import swpic_pkg::*;
#(
   parameter int NUM_SRC = 14,
   parameter int IW      = 4
) (
   input  logic [NUM_SRC-1:0]   req,
   input  logic [2*NUM_SRC-1:0] prio_flat,
   input  lvl_t                 cur,
   output logic                 hit,
   output logic [IW-1:0]        idx,
   output lvl_t                 lvl
);
   logic [1:0] best_rank;
   logic [1:0] cur_rank;
   logic [1:0] r_i;

   // scan downward so that an equal rank at a lower index replaces
   always_comb begin
      hit       = 1'b0;
      idx       = '0;
      lvl       = LVL_R0;
      best_rank = 2'd0;
      cur_rank  = lvl_rank(cur);
      r_i       = 2'd0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         r_i = lvl_rank(prio_flat[2*i +: 2]);
         if (req[i] && (r_i > cur_rank) && (!hit || r_i >= best_rank)) begin
            hit       = 1'b1;
            idx       = IW'(i);
            lvl       = prio_flat[2*i +: 2];
            best_rank = r_i;
         end
      end
   end
endmodule

// File: rtl/swpic_lvl_stack.sv
module swpic_lvl_stack #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         clear,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  mem [DEPTH];
   logic [CW-1:0] cnt;
   logic [PW-1:0] wr_idx;
   logic [PW-1:0] rd_idx;

   assign empty  = (cnt == '0);
   assign full   = (cnt == CW'(DEPTH));
   assign wr_idx = PW'(cnt);
   assign rd_idx = PW'(cnt - CW'(1));
   assign dout   = empty ? '0 : mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (push && !full)
         cnt <= cnt + CW'(1);
      else if (pop && !empty)
         cnt <= cnt - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (push && !full && !clear)
         mem[wr_idx] <= din;
   end

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> empty);
endmodule

// File: rtl/swpic_top.sv
module swpic_top
   import swpic_pkg::*;
#(
   parameter int          NUM_SRC       = 14,
   parameter int          STK_DEPTH     = 4,
   parameter logic [15:0] SRC_VEC_TOP   = 16'hFFF8,
   parameter logic [15:0] SRC_VEC_FLOOR = 16'hFFE0,
   parameter logic [15:0] TRAP_VEC      = 16'hFFFA,
   parameter logic [15:0] RESET_VEC     = 16'hFFFE,
   localparam int NREG = (NUM_SRC + 3) / 4,
   localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int IW   = $clog2(NUM_SRC + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               trap_req,
   input  logic               rst_req,
   input  logic               iret,
   input  logic               op_en,
   input  logic               op_dis,
   input  logic               op_pop,
   input  logic [1:0]         pop_lvl,
   input  logic               pr_we,
   input  logic [AW-1:0]      pr_addr,
   input  logic [7:0]         pr_wdata,
   output logic [7:0]         pr_rdata,
   output logic [1:0]         cur_lvl,
   output logic               grant,
   output logic [IW-1:0]      grant_src,
   output logic [15:0]        grant_vec
);
   localparam logic [IW-1:0] TRAP_ID = IW'(NUM_SRC);
   localparam logic [IW-1:0] RST_ID  = IW'(NUM_SRC + 1);

   if (NUM_SRC < 1 || NUM_SRC > 30) begin : g_chk_src
      $error("swpic_top: NUM_SRC out of range");
   end
   if (STK_DEPTH < 4) begin : g_chk_depth
      $error("swpic_top: STK_DEPTH must be at least 4");
   end

   logic [2*NUM_SRC-1:0] prio_flat;
   logic                 arb_hit;
   logic [IW-1:0]        arb_idx;
   lvl_t                 arb_lvl;
   lvl_t                 cur_q, nxt_lvl;
   lvl_t                 stk_top;
   logic                 stk_empty, stk_full;
   logic                 do_push, do_pop, do_clr;
   logic                 trap_pend, trap_live, take_trap;
   logic                 g_nxt;
   logic [IW-1:0]        gsrc_nxt;
   logic [15:0]          gvec_nxt;
   logic [15:0]          vtab [NUM_SRC];

   swpic_prio_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (pr_we),
      .addr      (pr_addr),
      .wdata     (pr_wdata),
      .rdata     (pr_rdata),
      .prio_flat (prio_flat)
   );

   swpic_arbiter #(.NUM_SRC(NUM_SRC), .IW(IW)) u_arb (
      .req       (irq_req),
      .prio_flat (prio_flat),
      .cur       (cur_q),
      .hit       (arb_hit),
      .idx       (arb_idx),
      .lvl       (arb_lvl)
   );

   swpic_lvl_stack #(.DEPTH(STK_DEPTH), .W(2)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (do_push),
      .pop   (do_pop),
      .clear (do_clr),
      .din   (cur_q),
      .dout  (stk_top),
      .empty (stk_empty),
      .full  (stk_full)
   );

   // vector per source: fixed 2-byte step, clamped at the floor
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
      localparam int RAW = int'(SRC_VEC_TOP) - 2 * g;
      if (RAW < int'(SRC_VEC_FLOOR)) begin : g_clamp
         assign vtab[g] = SRC_VEC_FLOOR;
      end else begin : g_step
         assign vtab[g] = 16'(RAW);
      end
   end

   assign trap_live = trap_pend | trap_req;

   always_comb begin
      nxt_lvl   = cur_q;
      do_push   = 1'b0;
      do_pop    = 1'b0;
      do_clr    = 1'b0;
      take_trap = 1'b0;
      g_nxt     = 1'b0;
      gsrc_nxt  = '0;
      gvec_nxt  = '0;
      if (rst_req) begin
         nxt_lvl  = LVL_R3;
         do_clr   = 1'b1;
         g_nxt    = 1'b1;
         gsrc_nxt = RST_ID;
         gvec_nxt = RESET_VEC;
      end else if (iret) begin
         if (!stk_empty) begin
            nxt_lvl = stk_top;
            do_pop  = 1'b1;
         end
      end else if (op_en) begin
         nxt_lvl = LVL_R0;
      end else if (op_dis) begin
         nxt_lvl = LVL_R3;
      end else if (op_pop) begin
         nxt_lvl = pop_lvl;
      end else if (trap_live && !stk_full) begin
         nxt_lvl   = LVL_R3;
         do_push   = 1'b1;
         take_trap = 1'b1;
         g_nxt     = 1'b1;
         gsrc_nxt  = TRAP_ID;
         gvec_nxt  = TRAP_VEC;
      end else if (arb_hit && !stk_full) begin
         nxt_lvl  = arb_lvl;
         do_push  = 1'b1;
         g_nxt    = 1'b1;
         gsrc_nxt = arb_idx;
         gvec_nxt = vtab[arb_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= LVL_R3;
         trap_pend <= 1'b0;
         grant     <= 1'b0;
         grant_src <= '0;
         grant_vec <= '0;
      end else begin
         cur_q     <= nxt_lvl;
         trap_pend <= trap_live && !take_trap && !rst_req;
         grant     <= g_nxt;
         grant_src <= gsrc_nxt;
         grant_vec <= gvec_nxt;
      end
   end

   assign cur_lvl = cur_q;

   p_grant_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && grant_src < TRAP_ID) |-> (lvl_rank(cur_lvl) > lvl_rank($past(cur_lvl))));

   p_trap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && grant_src == TRAP_ID) |-> (cur_lvl == LVL_R3));

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (grant && grant_src == RST_ID && cur_lvl == LVL_R3));

   p_event_nogrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((iret || op_en || op_dis || op_pop) && !rst_req) |=> !grant);

   p_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && !rst_req && !iret) |=> (cur_lvl == LVL_R0));

   p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_full && !rst_req) |=> !grant);
endmodule

// File: tb/sim_swpic_top.sv
module sim_swpic_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] irq_req = '0;
   logic        trap_req = 1'b0, rst_req = 1'b0, iret = 1'b0;
   logic        op_en = 1'b0, op_dis = 1'b0, op_pop = 1'b0;
   logic [1:0]  pop_lvl = 2'b00;
   logic        pr_we = 1'b0;
   logic [1:0]  pr_addr = '0;
   logic [7:0]  pr_wdata = '0;
   logic [7:0]  pr_rdata;
   logic [1:0]  cur_lvl;
   logic        grant;
   logic [3:0]  grant_src;
   logic [15:0] grant_vec;

   int checks = 0;
   int failures = 0;
   logic [7:0] mdl [4];

   always #10 clk = ~clk;

   swpic_top u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_req(trap_req),
      .rst_req(rst_req), .iret(iret), .op_en(op_en), .op_dis(op_dis),
      .op_pop(op_pop), .pop_lvl(pop_lvl), .pr_we(pr_we), .pr_addr(pr_addr),
      .pr_wdata(pr_wdata), .pr_rdata(pr_rdata), .cur_lvl(cur_lvl),
      .grant(grant), .grant_src(grant_src), .grant_vec(grant_vec)
   );

   function automatic int brank(input logic [1:0] c);
      if (c == 2'b11) return 3;
      if (c == 2'b00) return 2;
      if (c == 2'b01) return 1;
      return 0;
   endfunction

   function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] nw);
      logic [7:0] r = old;
      for (int k = 0; k < 4; k++)
         if (nw[2*k +: 2] != 2'b10) r[2*k +: 2] = nw[2*k +: 2];
      return r;
   endfunction

   function automatic logic [1:0] fld(input int i);
      logic [7:0] b = mdl[i/4];
      return b[2*(i%4) +: 2];
   endfunction

   function automatic int exp_win(input logic [13:0] rq, input int cr);
      int best = -1;
      int br = -1;
      for (int i = 0; i < 14; i++)
         if (rq[i] && brank(fld(i)) > cr && brank(fld(i)) > br) begin
            best = i;
            br = brank(fld(i));
         end
      return best;
   endfunction

   function automatic logic [15:0] exp_vec(input int i);
      if (i >= 12) return 16'hFFE0;
      return 16'(32'hFFF8 - 2 * i);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic wr(input int r, input logic [7:0] b);
      pr_we = 1'b1; pr_addr = 2'(r); pr_wdata = b;
      tick();
      pr_we = 1'b0;
      mdl[r] = merge(mdl[r], b);
   endtask

   task automatic rd_chk(input int r, input string tag);
      pr_addr = 2'(r);
      #1;
      check(tag, int'(pr_rdata), int'(mdl[r]));
   endtask

   task automatic exp_grant(input string tag, input int src, input logic [15:0] vec,
                            input logic [1:0] lvl);
      check({tag, " grant"}, int'(grant), 1);
      check({tag, " src"}, int'(grant_src), src);
      check({tag, " vec"}, int'(grant_vec), int'(vec));
      check({tag, " lvl"}, int'(cur_lvl), int'(lvl));
   endtask

   task automatic exp_none(input string tag, input logic [1:0] lvl);
      check({tag, " nogrant"}, int'(grant), 0);
      check({tag, " lvl"}, int'(cur_lvl), int'(lvl));
   endtask

   task automatic do_rst_req;
      rst_req = 1'b1; tick(); rst_req = 1'b0;
      exp_grant("R7 restart", 15, 16'hFFFE, 2'b11);
   endtask

   task automatic do_en;
      op_en = 1'b1; tick(); op_en = 1'b0;
      exp_none("R9 enable", 2'b10);
   endtask

   task automatic do_iret;
      iret = 1'b1; tick(); iret = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int r = 0; r < 4; r++) mdl[r] = 8'hFF;
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      exp_none("R1 reset", 2'b11);
      for (int r = 0; r < 4; r++) rd_chk(r, "R1 regs");

      // R2 field-wise rejection of code 10
      wr(0, 8'hCF); rd_chk(0, "R2 write CF");
      wr(0, 8'h64); rd_chk(0, "R2 CF then 64");
      check("R2 value 44", int'(pr_rdata), 8'h44);

      // R3 masked at level 3, R9 no grant in event cycle
      irq_req = 14'h0001; tick(); exp_none("R3 masked", 2'b11);
      op_en = 1'b1; tick(); op_en = 1'b0; exp_none("R9 event cycle", 2'b10);
      tick(); exp_grant("R5 src0", 0, 16'hFFF8, 2'b00);
      tick(); exp_none("R3 equal level", 2'b00);
      irq_req = 14'h0003; tick(); exp_none("R3 lower level", 2'b00);
      do_iret(); exp_none("R8 pop", 2'b10);
      tick(); exp_grant("R8 rearbitrate", 0, 16'hFFF8, 2'b00);
      irq_req = '0; do_rst_req();

      // R4 tie order
      do_en(); irq_req = 14'h0005; tick(); exp_grant("R4 tie", 0, 16'hFFF8, 2'b00);
      irq_req = '0; do_rst_req();
      do_en(); irq_req = 14'h0004; tick(); exp_grant("R5 src2", 2, 16'hFFF4, 2'b00);
      irq_req = '0; do_rst_req();

      // R10 raise while in service
      do_en(); irq_req = 14'h0002; tick(); exp_grant("R10 first", 1, 16'hFFF6, 2'b01);
      wr(0, 8'hAE); exp_none("R10 write cycle", 2'b01);
      rd_chk(0, "R2 AE merge");
      tick(); exp_grant("R10 reentry", 1, 16'hFFF6, 2'b11);
      irq_req = '0; do_rst_req();
      // R10 lower while in service
      do_en(); irq_req = 14'h0001; tick(); exp_grant("R10 src0", 0, 16'hFFF8, 2'b00);
      wr(0, 8'hA9); exp_none("R10 lowered", 2'b00);
      tick(); exp_none("R10 level kept", 2'b00);
      do_iret(); exp_none("R8 pop after lower", 2'b10);
      tick(); exp_grant("R10 new level", 0, 16'hFFF8, 2'b01);
      irq_req = '0; do_rst_req();

      // R6 trap and R9 pop
      trap_req = 1'b1; tick(); trap_req = 1'b0;
      exp_grant("R6 trap", 14, 16'hFFFA, 2'b11);
      tick(); exp_none("R6 trap once", 2'b11);
      do_iret(); exp_none("R8 trap return", 2'b11);
      op_pop = 1'b1; pop_lvl = 2'b01; tick(); op_pop = 1'b0;
      exp_none("R9 pop level", 2'b01);
      op_dis = 1'b1; tick(); op_dis = 1'b0;
      exp_none("R9 disable", 2'b11);
      do_iret(); exp_none("R8 empty iret", 2'b11);
      do_rst_req();

      // R11 full stack
      wr(1, 8'hF1);
      do_en();
      irq_req = 14'h0010; tick(); exp_grant("R11 n1", 4, 16'hFFF0, 2'b01);
      irq_req = 14'h0030; tick(); exp_grant("R11 n2", 5, 16'hFFEE, 2'b00);
      irq_req = 14'h0070; tick(); exp_grant("R11 n3", 6, 16'hFFEC, 2'b11);
      trap_req = 1'b1; tick(); trap_req = 1'b0;
      exp_grant("R11 n4 trap", 14, 16'hFFFA, 2'b11);
      op_pop = 1'b1; pop_lvl = 2'b10; tick(); op_pop = 1'b0;
      exp_none("R9 pop to 10", 2'b10);
      tick(); exp_none("R11 maskable blocked", 2'b10);
      trap_req = 1'b1; tick(); trap_req = 1'b0;
      exp_none("R11 trap blocked", 2'b10);
      do_iret(); exp_none("R8 unwind", 2'b11);
      tick(); exp_grant("R11 trap resumes", 14, 16'hFFFA, 2'b11);
      irq_req = '0; do_rst_req();

      // R5 last source shares floor vector
      wr(3, 8'hF7);
      do_en(); irq_req = 14'h2000; tick(); exp_grant("R5 src13", 13, 16'hFFE0, 2'b01);
      irq_req = '0; do_rst_req();

      // random phase
      for (int t = 0; t < 40; t++) begin
         int r;
         int w;
         logic [13:0] rq;
         r = int'($urandom % 4);
         wr(r, 8'($urandom));
         rd_chk(r, "R2 random");
         do_rst_req();
         do_en();
         rq = 14'($urandom);
         irq_req = rq;
         tick();
         w = exp_win(rq, 0);
         if (w < 0) exp_none("R3 random none", 2'b10);
         else exp_grant("R4 random", w, exp_vec(w), fld(w));
         irq_req = '0;
      end
      do_rst_req();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule